// File: doc/BRIEF.md
# Serial-Bus Core Control and Status Register File

This block holds the core control and status registers of a node on a serial bus. It accepts read and write requests that carry a byte offset, a byte length and, for writes, one data quadlet. It answers each request with a response code of complete, type error or address error. A read of one or more quadlets streams one data beat per cycle. The registers are the node state, the node identity, the two halves of the split-transaction timeout, the cycle time, the bus time and the broadcast channel.

The block turns the split-timeout pair into an expiry time in microseconds and holds that value to a lower bound. A free-running cycle-counter input stands in for the counter hardware. Each read of the cycle-time or bus-time register samples this counter, and the bus-time register counts up by itself when the sample shows that the counter has wrapped. A bus-reset strobe puts the state, node-identity and broadcast registers back into their post-reset form.

Top module: `sbus_csr_regfile`

## Requirements
- R1: A request whose offset or length is not a multiple of 4 ends with a type error, reported as `rsp_code` 1. The other codes are 0 for complete and 2 for address error.
- R2: The registers sit at these byte offsets: 0x000 and 0x004 state, 0x008 node identity, 0x00C reset-start, 0x018 split-timeout high, 0x01C split-timeout low, 0x200 cycle time, 0x204 bus time, 0x234 broadcast channel. A read of reset-start gives a type error. Any other offset, including 0x210, gives an address error.
- R3: A write to split-timeout high keeps only bits [2:0]. A write to split-timeout low keeps only bits [31:19].
- R4: `expiry_us` equals high×1,000,000 plus (low>>19)×125, and never drops below 100,000. It follows a register write one clock edge later.
- R5: After power-up reset, split-timeout low reads 0x1900_0000 and split-timeout high reads 0. Both state offsets read STATE_INIT (default 0x0000_0B05). The node identity reads 0, the broadcast channel reads 0x8000_001F and `expiry_us` is 100,000.
- R6: A read of cycle time or bus time first samples `cyc_count`. A cycle-time read returns that sample. If the sample is below the previously held cycle time, bus time grows by 128 before it is used.
- R7: A bus-time read returns the stored bus time OR'd with `cyc_count>>25`. A bus-time write keeps bits [31:7]. A cycle-time write replaces the held cycle time, and later wrap detection compares against that value.
- R8: A write to the broadcast channel changes only bit 30. All other bits keep their values.
- R9: A node-identity write replaces only the bus field in bits [31:22]. A bus reset loads `phy_node` into the node field in bits [21:16] and leaves the bus field alone.
- R10: A bus reset clears every state bit except [9:8], and also clears bit 8 when `is_root` is low. It returns the broadcast channel to 0x8000_001F.
- R11: A multi-quadlet read visits consecutive offsets and gives one beat per quadlet. The first quadlet that fails ends the request with that quadlet's code, and the failing quadlet gives no beat. A zero-length read completes at once with no beats.
- R12: A write carries exactly one quadlet. A write length other than 4 gives a type error. Writes to state and reset-start complete and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 12 | Byte offset into the register space |
| req_len | input | LEN_W | Request length in bytes |
| req_wdata | input | 32 | Write quadlet |
| rd_valid | output | 1 | Read beat present |
| rd_data | output | 32 | Read beat data |
| rsp_done | output | 1 | Request finished, code valid |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| cyc_count | input | 32 | Free-running cycle-counter value |
| bus_reset | input | 1 | Bus-reset re-initialisation strobe |
| is_root | input | 1 | Node is root at this bus reset |
| phy_node | input | 6 | Node number loaded at bus reset |
| expiry_us | output | EXP_W | Split-transaction expiry in microseconds |

## Verification
A write, a misaligned request or a zero-length read raises `rsp_done` on the clock edge that accepts it. A read of N quadlets gives beat k on the k-th edge after acceptance and raises `rsp_done` together with the last beat. `expiry_us` changes one edge after the split-timeout register is written. The bench drives requests on falling edges and samples on the falling edge after each due edge. It checks that every beat arrives in the cycle it is due, and it waits one extra cycle before it compares the expiry value.

// File: rtl/sbus_csr_pkg.sv
package sbus_csr_pkg;

  localparam int OFFS_W = 12;

  typedef enum logic [1:0] {
    RSP_COMPLETE = 2'd0,
    RSP_TYPE_ERR = 2'd1,
    RSP_ADDR_ERR = 2'd2
  } rsp_code_e;

  localparam logic [OFFS_W-1:0] OFF_ST_CLR   = 12'h000;
  localparam logic [OFFS_W-1:0] OFF_ST_SET   = 12'h004;
  localparam logic [OFFS_W-1:0] OFF_NODE     = 12'h008;
  localparam logic [OFFS_W-1:0] OFF_RST_GO   = 12'h00C;
  localparam logic [OFFS_W-1:0] OFF_SPLIT_HI = 12'h018;
  localparam logic [OFFS_W-1:0] OFF_SPLIT_LO = 12'h01C;
  localparam logic [OFFS_W-1:0] OFF_CYCLE    = 12'h200;
  localparam logic [OFFS_W-1:0] OFF_BUSTIME  = 12'h204;
  localparam logic [OFFS_W-1:0] OFF_BCAST    = 12'h234;

  localparam logic [31:0] BCAST_INIT     = 32'h8000_001F;
  localparam logic [31:0] BCAST_VLD_MASK = 32'h4000_0000;
  localparam logic [31:0] BUSTIME_MASK   = 32'hFFFF_FF80;
  localparam logic [31:0] STATE_KEEP     = 32'h0000_0300;
  localparam logic [31:0] STATE_CMSTR    = 32'h0000_0100;

  function automatic rsp_code_e rd_status(input logic [OFFS_W-1:0] off);
    case (off)
      OFF_ST_CLR, OFF_ST_SET, OFF_NODE, OFF_SPLIT_HI, OFF_SPLIT_LO,
      OFF_CYCLE, OFF_BUSTIME, OFF_BCAST: rd_status = RSP_COMPLETE;
      OFF_RST_GO:                        rd_status = RSP_TYPE_ERR;
      default:                           rd_status = RSP_ADDR_ERR;
    endcase
  endfunction

  function automatic rsp_code_e wr_status(input logic [OFFS_W-1:0] off);
    case (off)
      OFF_ST_CLR, OFF_ST_SET, OFF_NODE, OFF_RST_GO, OFF_SPLIT_HI,
      OFF_SPLIT_LO, OFF_CYCLE, OFF_BUSTIME, OFF_BCAST: wr_status = RSP_COMPLETE;
      default:                                       wr_status = RSP_ADDR_ERR;
    endcase
  endfunction

endpackage

// File: rtl/csr_timebase.sv
module csr_timebase (
  input  logic        clk,
  input  logic        rst,
  input  logic        sample,
  input  logic        wr_cycle,
  input  logic        wr_bus,
  input  logic [31:0] wdata,
  input  logic [31:0] cyc_count,
  output logic [31:0] bus_rd
);
  import sbus_csr_pkg::*;

  logic [31:0] cycle_q, bus_q, bus_next;
  logic        wrapped;

  assign wrapped  = sample && (cyc_count < cycle_q);
  assign bus_next = wrapped ? bus_q + 32'd128 : bus_q;
  assign bus_rd   = bus_next | {25'd0, cyc_count[31:25]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_q <= '0;
      bus_q   <= '0;
    end else if (wr_cycle) begin
      cycle_q <= wdata;
    end else if (wr_bus) begin
      bus_q <= wdata & BUSTIME_MASK;
    end else if (sample) begin
      cycle_q <= cyc_count;
      bus_q   <= bus_next;
    end
  end

  // R6: a counter wrap seen by a sample extends bus time by 128
  a_r6_wrap_extends: assert property (@(posedge clk) disable iff (rst)
    (sample && cyc_count < cycle_q) |=> bus_q == $past(bus_q) + 32'd128);

  // R6: without a wrap a sample leaves bus time unchanged
  a_r6_no_wrap_hold: assert property (@(posedge clk) disable iff (rst)
    (sample && cyc_count >= cycle_q) |=> bus_q == $past(bus_q));

endmodule

// File: rtl/csr_expiry.sv
module csr_expiry #(
  parameter int EXP_W    = 24,
  parameter int FLOOR_US = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       sec,
  input  logic [12:0]      units,
  output logic [EXP_W-1:0] expiry_us
);
  localparam logic [EXP_W-1:0] SEC_US   = EXP_W'(1000000);
  localparam logic [EXP_W-1:0] UNIT_US  = EXP_W'(125);
  localparam logic [EXP_W-1:0] FLOOR_V  = EXP_W'(FLOOR_US);

  logic [EXP_W-1:0] raw;

  assign raw = EXP_W'(sec) * SEC_US + EXP_W'(units) * UNIT_US;

  always_ff @(posedge clk) begin
    if (rst) expiry_us <= FLOOR_V;
    else     expiry_us <= (raw < FLOOR_V) ? FLOOR_V : raw;
  end

  // R4: the derived expiry never falls below the floor
  a_r4_floor: assert property (@(posedge clk) disable iff (rst)
    expiry_us >= FLOOR_V);

endmodule

// File: rtl/sbus_csr_regfile.sv
module sbus_csr_regfile
  import sbus_csr_pkg::*;
#(
  parameter int          LEN_W      = 8,
  parameter int          EXP_W      = 24,
  parameter int          FLOOR_US   = 100000,
  parameter logic [31:0] STATE_INIT = 32'h0000_0B05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [11:0]       req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              rsp_done,
  output logic [1:0]        rsp_code,
  input  logic [31:0]       cyc_count,
  input  logic              bus_reset,
  input  logic              is_root,
  input  logic [5:0]        phy_node,
  output logic [EXP_W-1:0]  expiry_us
);
  localparam int          CNT_W      = LEN_W - 2;
  localparam logic [12:0] SPLIT_INIT = 13'd800;

  logic              busy_q;
  logic [OFFS_W-1:0] cur_off;
  logic [CNT_W-1:0]  left_q;
  logic [31:0]       state_q, node_q, bcast_q;
  logic [2:0]        split_hi_q;
  logic [12:0]       split_lo_q;
  logic [31:0]       bus_rd, rd_mux;
  rsp_code_e         cur_code, wcode;
  logic              accept, misal, wr_go, sample;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign misal     = (req_offset[1:0] != 2'b00) || (req_len[1:0] != 2'b00);
  assign wcode     = wr_status(req_offset);
  assign wr_go     = accept && req_write && !misal && (req_len == LEN_W'(4)) &&
                     (wcode == RSP_COMPLETE);
  assign cur_code  = rd_status(cur_off);
  assign sample    = busy_q && ((cur_off == OFF_CYCLE) || (cur_off == OFF_BUSTIME));

  csr_timebase u_timebase (
    .clk       (clk),
    .rst       (rst),
    .sample    (sample),
    .wr_cycle  (wr_go && req_offset == OFF_CYCLE),
    .wr_bus    (wr_go && req_offset == OFF_BUSTIME),
    .wdata     (req_wdata),
    .cyc_count (cyc_count),
    .bus_rd    (bus_rd)
  );

  csr_expiry #(.EXP_W(EXP_W), .FLOOR_US(FLOOR_US)) u_expiry (
    .clk       (clk),
    .rst       (rst),
    .sec       (split_hi_q),
    .units     (split_lo_q),
    .expiry_us (expiry_us)
  );

  always_comb begin
    case (cur_off)
      OFF_ST_CLR, OFF_ST_SET: rd_mux = state_q;
      OFF_NODE:               rd_mux = node_q;
      OFF_SPLIT_HI:           rd_mux = {29'd0, split_hi_q};
      OFF_SPLIT_LO:           rd_mux = {split_lo_q, 19'd0};
      OFF_CYCLE:              rd_mux = cyc_count;
      OFF_BUSTIME:            rd_mux = bus_rd;
      OFF_BCAST:              rd_mux = bcast_q;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cur_off    <= '0;
      left_q     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rsp_done   <= 1'b0;
      rsp_code   <= RSP_COMPLETE;
      state_q    <= STATE_INIT;
      node_q     <= '0;
      bcast_q    <= BCAST_INIT;
      split_hi_q <= '0;
      split_lo_q <= SPLIT_INIT;
    end else begin
      rd_valid <= 1'b0;
      rsp_done <= 1'b0;
      if (accept) begin
        if (misal) begin
          rsp_done <= 1'b1;
          rsp_code <= RSP_TYPE_ERR;
        end else if (req_write) begin
          rsp_done <= 1'b1;
          rsp_code <= (req_len != LEN_W'(4)) ? RSP_TYPE_ERR : wcode;
          if (wr_go) begin
            case (req_offset)
              OFF_NODE:     node_q[31:22] <= req_wdata[31:22];
              OFF_SPLIT_HI: split_hi_q    <= req_wdata[2:0];
              OFF_SPLIT_LO: split_lo_q    <= req_wdata[31:19];
              OFF_BCAST:    bcast_q       <= (bcast_q & ~BCAST_VLD_MASK) |
                                             (req_wdata & BCAST_VLD_MASK);
              default: ;
            endcase
          end
        end else if (req_len == '0) begin
          rsp_done <= 1'b1;
          rsp_code <= RSP_COMPLETE;
        end else begin
          busy_q  <= 1'b1;
          cur_off <= req_offset;
          left_q  <= req_len[LEN_W-1:2];
        end
      end else if (busy_q) begin
        if (cur_code != RSP_COMPLETE) begin
          busy_q   <= 1'b0;
          rsp_done <= 1'b1;
          rsp_code <= cur_code;
        end else begin
          rd_valid <= 1'b1;
          rd_data  <= rd_mux;
          cur_off  <= cur_off + OFFS_W'(4);
          left_q   <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            busy_q   <= 1'b0;
            rsp_done <= 1'b1;
            rsp_code <= RSP_COMPLETE;
          end
        end
      end
      if (bus_reset) begin
        state_q       <= state_q & STATE_KEEP & (is_root ? 32'hFFFF_FFFF : ~STATE_CMSTR);
        node_q[21:16] <= phy_node;
        bcast_q       <= BCAST_INIT;
      end
    end
  end

  // R1: misaligned offset or length is answered with a type error next cycle
  a_r1_misalign: assert property (@(posedge clk) disable iff (rst)
    (accept && misal) |=> (rsp_done && rsp_code == RSP_TYPE_ERR));

  // R12: an aligned write of any length but 4 is a type error
  a_r12_write_len: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && !misal && req_len != LEN_W'(4))
      |=> (rsp_done && rsp_code == RSP_TYPE_ERR));

  // R2: reading reset-start fails with a type error
  a_r2_rst_go_read: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cur_off == OFF_RST_GO) |=> (rsp_done && rsp_code == RSP_TYPE_ERR && !rd_valid));

  // R9: a node-identity write leaves the node field untouched
  a_r9_node_keep: assert property (@(posedge clk) disable iff (rst)
    (wr_go && req_offset == OFF_NODE && !bus_reset)
      |=> node_q[21:16] == $past(node_q[21:16]));

  // R11: a data beat never comes with an error code
  a_r11_beat_ok: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rsp_done) |-> rsp_code == RSP_COMPLETE);

endmodule

// File: tb/test_sbus_csr_regfile.sv
module test_sbus_csr_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [11:0] req_offset;
  logic [7:0]  req_len;
  logic [31:0] req_wdata;
  logic        rd_valid, rsp_done;
  logic [31:0] rd_data;
  logic [1:0]  rsp_code;
  logic [31:0] cyc_count;
  logic        bus_reset, is_root;
  logic [5:0]  phy_node;
  logic [23:0] expiry_us;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] beat [0:7];
  int          nbeat;
  logic [1:0]  code;

  always #2 clk = ~clk;

  sbus_csr_regfile i_sbus_csr_regfile (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_len(req_len),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .rsp_done(rsp_done), .rsp_code(rsp_code), .cyc_count(cyc_count),
    .bus_reset(bus_reset), .is_root(is_root), .phy_node(phy_node),
    .expiry_us(expiry_us)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] off, input logic [7:0] len);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = off; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    nbeat = 0;
    code  = 2'd3;
    if (rsp_done) begin
      code = rsp_code;
      return;
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rd_valid) begin
        if (i != nbeat) chk("R11 beat cycle", i, nbeat);
        beat[nbeat] = rd_data;
        nbeat++;
      end
      if (rsp_done) begin
        code = rsp_code;
        break;
      end
    end
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d, input logic [7:0] len);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_len = len; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    code = rsp_done ? rsp_code : 2'd3;
  endtask

  task automatic rd1(input string tag, input logic [11:0] off, input logic [31:0] exp);
    rd(off, 8'd4);
    chk({tag, " code"}, code, 0);
    chk(tag, (nbeat == 1) ? beat[0] : 32'hDEAD_BEEF, exp);
  endtask

  task automatic pulse_bus_reset(input logic root, input logic [5:0] nd);
    @(negedge clk);
    bus_reset = 1'b1; is_root = root; phy_node = nd;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R5 ready", req_ready, 1);
    chk("R5 done idle", rsp_done, 0);
    chk("R5 expiry", expiry_us, 100000);
    rd1("R5 split lo", 12'h01C, 32'h1900_0000);
    rd1("R5 split hi", 12'h018, 0);
    rd1("R5 state clr", 12'h000, 32'h0000_0B05);
    rd1("R5 state set", 12'h004, 32'h0000_0B05);
    rd1("R5 node", 12'h008, 0);
    rd1("R5 bcast", 12'h234, 32'h8000_001F);
  endtask

  task automatic t_errors;
    rd(12'h01A, 8'd4);  chk("R1 misaligned offset", code, 1);
    rd(12'h018, 8'd6);  chk("R1 misaligned length", code, 1);
    wr(12'h019, 0, 8'd4); chk("R1 misaligned write", code, 1);
    rd(12'h00C, 8'd4);  chk("R2 reset-start read", code, 1);
    rd(12'h210, 8'd4);  chk("R2 busy-timeout read", code, 2);
    rd(12'h100, 8'd4);  chk("R2 gap read", code, 2);
    chk("R2 no beat on error", nbeat, 0);
  endtask

  task automatic t_split;
    wr(12'h018, 32'hFFFF_FFFD, 8'd4); chk("R3 write code", code, 0);
    wr(12'h01C, 32'hFFFF_FFFF, 8'd4);
    @(negedge clk);
    chk("R4 expiry max", expiry_us, 6023875);
    rd1("R3 hi mask", 12'h018, 5);
    rd1("R3 lo mask", 12'h01C, 32'hFFF8_0000);
    wr(12'h018, 0, 8'd4);
    @(negedge clk);
    chk("R4 expiry lo only", expiry_us, 1023875);
    wr(12'h01C, 32'h0008_0000, 8'd4);
    @(negedge clk);
    chk("R4 expiry floor", expiry_us, 100000);
    wr(12'h01C, 32'h1F40_0000, 8'd4);
    @(negedge clk);
    chk("R4 expiry above floor", expiry_us, 125000);
  endtask

  task automatic t_time;
    cyc_count = 32'h0000_1000;
    rd1("R6 cycle sample", 12'h200, 32'h0000_1000);
    wr(12'h204, 32'h0000_12FF, 8'd4);
    rd1("R7 bus mask", 12'h204, 32'h0000_1280);
    cyc_count = 32'h0600_0000;
    rd1("R7 bus or cycle", 12'h204, 32'h0000_1283);
    cyc_count = 32'h0000_0010;
    rd1("R6 wrap extend", 12'h204, 32'h0000_1300);
    rd1("R6 no second wrap", 12'h204, 32'h0000_1300);
    wr(12'h200, 32'h7FFF_0000, 8'd4);
    cyc_count = 32'h0000_0100;
    rd1("R7 cycle write wraps", 12'h204, 32'h0000_1380);
  endtask

  task automatic t_bcast_node_state;
    wr(12'h234, 32'hFFFF_FFFF, 8'd4);
    rd1("R8 valid set", 12'h234, 32'hC000_001F);
    wr(12'h234, 32'h0000_0000, 8'd4);
    rd1("R8 valid clear", 12'h234, 32'h8000_001F);
    wr(12'h234, 32'h4000_0000, 8'd4);
    pulse_bus_reset(1'b1, 6'd5);
    rd1("R10 bcast restore", 12'h234, 32'h8000_001F);
    rd1("R10 root state", 12'h000, 32'h0000_0300);
    rd1("R9 node load", 12'h008, 32'h0005_0000);
    wr(12'h008, 32'hFFFF_FFFF, 8'd4);
    rd1("R9 bus field", 12'h008, 32'hFFC5_0000);
    wr(12'h004, 32'hFFFF_FFFF, 8'd4); chk("R12 state write code", code, 0);
    wr(12'h000, 32'hFFFF_FFFF, 8'd4);
    wr(12'h00C, 32'hFFFF_FFFF, 8'd4); chk("R12 reset-start write code", code, 0);
    rd1("R12 state unchanged", 12'h004, 32'h0000_0300);
    pulse_bus_reset(1'b0, 6'd9);
    rd1("R10 non-root state", 12'h000, 32'h0000_0200);
    rd1("R9 bus kept", 12'h008, 32'hFFC9_0000);
  endtask

  task automatic t_multi;
    rd(12'h018, 8'd8);
    chk("R11 pair code", code, 0);
    chk("R11 pair beats", nbeat, 2);
    chk("R11 beat0", beat[0], 0);
    chk("R11 beat1", beat[1], 32'h1F40_0000);
    rd(12'h008, 8'd12);
    chk("R11 abort code", code, 1);
    chk("R11 abort beats", nbeat, 1);
    chk("R11 abort beat0", beat[0], 32'hFFC9_0000);
    rd(12'h200, 8'd8);
    chk("R11 time pair", {beat[0][15:0], beat[1][15:0]}, 32'h0100_1380);
    rd(12'h000, 8'd0);
    chk("R11 zero len", code, 0);
    chk("R11 zero len beats", nbeat, 0);
    wr(12'h018, 32'h7, 8'd8); chk("R12 write len", code, 1);
    rd1("R12 len error no write", 12'h018, 0);
    wr(12'h210, 32'h7, 8'd4); chk("R2 busy-timeout write", code, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_offset = '0;
    req_len = '0; req_wdata = '0; cyc_count = '0; bus_reset = 1'b0;
    is_root = 1'b0; phy_node = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state;
    t_errors;
    t_split;
    t_time;
    t_bcast_node_state;
    t_multi;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule